// File: doc/BRIEF.md
# Packed 8-bit dot-product accumulator

This unit multiplies 8-bit lanes packed into two 32-bit operands, adds up the lane products, and adds a 32-bit accumulator operand. It returns the total one clock later with a valid flag. It supports two shapes of operation. The pair shape uses two lanes from one 16-bit half of each operand, and a half-select input chooses the lower or the upper half. The quad shape uses all four bytes of each operand.

The lanes of the first operand are signed or unsigned, as a per-operation signedness input selects. The lanes of the second operand are always unsigned. The unit sign-extends or zero-extends every lane product to the full word width before it adds them. The final sum wraps modulo 2^32, so the accumulator operand may carry either a signed or an unsigned 32-bit value.

Top module: `dot8_acc`

## Requirements
- R1: With `mode_quad`=0 and `hi_half`=0, the lanes are bits [7:0] and [15:8] of each operand. Bits [31:16] of both operands have no effect on the result.
- R2: With `mode_quad`=0 and `hi_half`=1, the lanes are bits [23:16] and [31:24] of each operand. Bits [15:0] of both operands have no effect on the result.
- R3: With `mode_quad`=1, all four bytes of each operand form lanes (byte i is bits [8i+7:8i]), and `hi_half` has no effect on the result.
- R4: With `src1_signed`=1, each `src1` lane is a two's-complement value from -128 to 127. With `src1_signed`=0, each lane is a value from 0 to 255.
- R5: Each `src2` lane is always an unsigned value from 0 to 255, whatever `src1_signed` holds.
- R6: `result` equals `src3` plus the sum of the lane products, taken modulo 2^32.
- R7: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise. `result` holds the matching value in that same cycle.
- R8: While `in_valid` is 0, `result` keeps its last value whatever the other inputs do.
- R9: While `rst_n` is 0, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| mode_quad | input | 1 | 0: two lanes from one half-word; 1: four lanes |
| hi_half | input | 1 | Selects the half-word in two-lane mode (1 = upper) |
| src1_signed | input | 1 | 1: lanes of src1 are signed |
| src1 | input | 32 | First packed operand |
| src2 | input | 32 | Second packed operand, unsigned lanes |
| src3 | input | 32 | Accumulator operand |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Dot product plus accumulator |

## Verification
The hardest case to reach from the ports is a sum that wraps. Signed negative lane products must borrow through the full word, and that borrow has to interact with an accumulator near the top or bottom of the 32-bit range. The directed stimulus sets up both directions of wrap. It drives -1 lanes against 255 lanes onto a small accumulator, which forces a borrow below zero. It also drives maximal unsigned lanes onto an all-ones accumulator, which forces a carry out. The stimulus also places distinct junk in the unused half-word and toggles the half-select in quad mode, so that a miswired lane shows up as a wrong value.

// File: rtl/dot8_pkg.sv
package dot8_pkg;
   localparam int unsigned DEF_LANE_W = 8;
   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_DATA_W = 32;

   typedef enum logic {
      SHAPE_PAIR = 1'b0,
      SHAPE_QUAD = 1'b1
   } shape_e;

   typedef enum int unsigned {
      SUM_CHAIN = 0,
      SUM_SPLIT = 1
   } sum_style_e;
endpackage

// File: rtl/dot8_lane_sel.sv
module dot8_lane_sel
   import dot8_pkg::*;
#(
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter int unsigned LANES  = DEF_LANES,
   localparam int unsigned SRC_W = LANE_W * LANES,
   localparam int unsigned HALF_LANES = LANES / 2
) (
   input  shape_e                        shape,
   input  logic                          upper,
   input  logic [SRC_W-1:0]              src,
   output logic [LANES-1:0][LANE_W-1:0]  lane_o
);
   initial begin
      if (LANES < 2 || (LANES % 2) != 0)
         $error("dot8_lane_sel: LANES must be even and at least 2");
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic [LANE_W-1:0] full_byte;
      assign full_byte = src[gi*LANE_W +: LANE_W];
      if (gi < HALF_LANES) begin : g_pair_slot
         logic [LANE_W-1:0] pair_byte;
         assign pair_byte = upper ? src[(gi+HALF_LANES)*LANE_W +: LANE_W]
                                  : src[gi*LANE_W +: LANE_W];
         assign lane_o[gi] = (shape == SHAPE_QUAD) ? full_byte : pair_byte;
      end else begin : g_quad_slot
         assign lane_o[gi] = (shape == SHAPE_QUAD) ? full_byte : '0;
      end
   end
endmodule

// File: rtl/dot8_lane_mul.sv
module dot8_lane_mul #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned OPND_W = LANE_W + 1,
   localparam int unsigned PROD_W = 2 * OPND_W
) (
   input  logic [LANE_W-1:0] a,
   input  logic              a_signed,
   input  logic [LANE_W-1:0] b,
   output logic [DATA_W-1:0] prod_o
);
   initial begin
      if (DATA_W <= PROD_W)
         $error("dot8_lane_mul: DATA_W must exceed the product width");
   end

   logic signed [OPND_W-1:0] a_ext;
   logic signed [OPND_W-1:0] b_ext;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      a_ext  = $signed({a_signed & a[LANE_W-1], a});
      b_ext  = $signed({1'b0, b});
      prod   = a_ext * b_ext;
      prod_o = {{(DATA_W-PROD_W){prod[PROD_W-1]}}, prod};
   end
endmodule

// File: rtl/dot8_sum.sv
module dot8_sum
   import dot8_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned LANES  = DEF_LANES,
   parameter sum_style_e  STYLE  = SUM_SPLIT,
   localparam int unsigned HALF_LANES = LANES / 2
) (
   input  logic [LANES-1:0][DATA_W-1:0] prod_i,
   input  logic [DATA_W-1:0]            acc_i,
   output logic [DATA_W-1:0]            sum_o
);
   if (STYLE == SUM_CHAIN) begin : g_chain
      always_comb begin
         sum_o = acc_i;
         for (int i = 0; i < LANES; i++) sum_o = sum_o + prod_i[i];
      end
   end else begin : g_split
      logic [DATA_W-1:0] lo_sum;
      logic [DATA_W-1:0] hi_sum;
      always_comb begin
         lo_sum = '0;
         hi_sum = '0;
         for (int i = 0; i < HALF_LANES; i++) begin
            lo_sum = lo_sum + prod_i[i];
            hi_sum = hi_sum + prod_i[i+HALF_LANES];
         end
         sum_o = acc_i + lo_sum + hi_sum;
      end
   end
endmodule

// File: rtl/dot8_acc.sv
module dot8_acc
   import dot8_pkg::*;
#(
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter int unsigned LANES  = DEF_LANES,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter sum_style_e  STYLE  = SUM_SPLIT,
   localparam int unsigned SRC_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              mode_quad,
   input  logic              hi_half,
   input  logic              src1_signed,
   input  logic [SRC_W-1:0]  src1,
   input  logic [SRC_W-1:0]  src2,
   input  logic [DATA_W-1:0] src3,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   initial begin
      if (SRC_W > DATA_W)
         $error("dot8_acc: packed operands wider than the data word");
   end

   shape_e                       shape;
   logic [LANES-1:0][LANE_W-1:0] lane_a;
   logic [LANES-1:0][LANE_W-1:0] lane_b;
   logic [LANES-1:0][DATA_W-1:0] lane_prod;
   logic [DATA_W-1:0]            total;

   assign shape = shape_e'(mode_quad);

   dot8_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) i_sel_a (
      .shape(shape), .upper(hi_half), .src(src1), .lane_o(lane_a));

   dot8_lane_sel #(.LANE_W(LANE_W), .LANES(LANES)) i_sel_b (
      .shape(shape), .upper(hi_half), .src(src2), .lane_o(lane_b));

   for (genvar gi = 0; gi < LANES; gi++) begin : g_mul
      dot8_lane_mul #(.LANE_W(LANE_W), .DATA_W(DATA_W)) i_mul (
         .a(lane_a[gi]), .a_signed(src1_signed), .b(lane_b[gi]),
         .prod_o(lane_prod[gi]));
   end

   dot8_sum #(.DATA_W(DATA_W), .LANES(LANES), .STYLE(STYLE)) i_sum (
      .prod_i(lane_prod), .acc_i(src3), .sum_o(total));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= total;
      end
   end
endmodule

// File: rtl/dot8_acc_chk.sv
module dot8_acc_chk #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned SRC_W = LANE_W * LANES,
   localparam longint unsigned LANE_MAX = (64'd1 << LANE_W) - 1,
   localparam longint unsigned U_BOUND = LANES * LANE_MAX * LANE_MAX
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              src1_signed,
   input logic [SRC_W-1:0]  src2,
   input logic [DATA_W-1:0] src3,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_zero_src2_gives_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src2 == '0) |=> result == $past(src3));

   assert_unsigned_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !src1_signed && src3 == '0) |=> 64'(result) <= U_BOUND);
endmodule

bind dot8_acc dot8_acc_chk #(.LANE_W(LANE_W), .LANES(LANES), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src1_signed(src1_signed),
   .src2(src2), .src3(src3), .out_valid(out_valid), .result(result));

// File: tb/test_dot8_acc.sv
`timescale 1ns/1ps
module test_dot8_acc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        mode_quad = 1'b0;
   logic        hi_half = 1'b0;
   logic        src1_signed = 1'b0;
   logic [31:0] src1 = '0;
   logic [31:0] src2 = '0;
   logic [31:0] src3 = '0;
   logic        out_valid;
   logic [31:0] result;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dot8_acc i_dot8_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_quad(mode_quad),
      .hi_half(hi_half), .src1_signed(src1_signed), .src1(src1), .src2(src2),
      .src3(src3), .out_valid(out_valid), .result(result));

   function automatic logic [31:0] model(input logic quad, input logic hi,
                                         input logic sg, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] c);
      longint acc = longint'(c);
      int first = (quad || !hi) ? 0 : 2;
      int count = quad ? 4 : 2;
      for (int k = first; k < first + count; k++) begin
         longint av = longint'(a[8*k +: 8]);
         longint bv = longint'(b[8*k +: 8]);
         if (sg && av > 127) av = av - 256;
         acc = acc + av * bv;
      end
      return acc[31:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic quad, input logic hi, input logic sg,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      @(negedge clk);
      in_valid = 1'b1; mode_quad = quad; hi_half = hi; src1_signed = sg;
      src1 = a; src2 = b; src3 = c;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_op(input string req, input logic quad, input logic hi, input logic sg,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      issue(quad, hi, sg, a, b, c);
      check({req, " valid"}, 32'(out_valid), 32'd1);
      check(req, result, model(quad, hi, sg, a, b, c));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 out_valid", 32'(out_valid), 32'd0);
      check("R9 result", result, 32'd0);
   endtask

   task automatic t_pair_low();
      run_op("R1", 1'b0, 1'b0, 1'b0, 32'hABCD_0305, 32'h7766_0204, 32'd10);
      check("R1 value", result, 32'd36);
      issue(1'b0, 1'b0, 1'b0, 32'h1234_0305, 32'h9988_0204, 32'd10);
      check("R1 upper ignored", result, 32'd36);
   endtask

   task automatic t_pair_high();
      run_op("R2", 1'b0, 1'b1, 1'b0, 32'h0307_FFEE, 32'h0502_1122, 32'd1);
      check("R2 value", result, 32'd30);
   endtask

   task automatic t_quad();
      run_op("R3", 1'b1, 1'b0, 1'b0, 32'h0102_0304, 32'h0506_0708, 32'd0);
      check("R3 value", result, 32'd70);
      issue(1'b1, 1'b1, 1'b0, 32'h0102_0304, 32'h0506_0708, 32'd0);
      check("R3 hi_half ignored", result, 32'd70);
   endtask

   task automatic t_signed();
      run_op("R4 signed", 1'b1, 1'b0, 1'b1, 32'hFF80_7F01, 32'h0102_0304, 32'd1000);
      run_op("R4 unsigned", 1'b1, 1'b0, 1'b0, 32'hFF80_7F01, 32'h0102_0304, 32'd1000);
   endtask

   task automatic t_src2_unsigned();
      run_op("R5", 1'b0, 1'b0, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 32'd0);
      check("R5 value", result, 32'hFFFF_FE02);
   endtask

   task automatic t_wrap();
      run_op("R6 carry", 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op("R6 borrow", 1'b1, 1'b1, 1'b1, 32'h8080_8080, 32'hFFFF_FFFF, 32'd5);
   endtask

   task automatic t_latency_hold();
      logic [31:0] held;
      issue(1'b1, 1'b0, 1'b0, 32'h0202_0202, 32'h0303_0303, 32'd7);
      check("R7 valid", 32'(out_valid), 32'd1);
      held = result;
      @(negedge clk);
      check("R7 valid drops", 32'(out_valid), 32'd0);
      mode_quad = 1'b0; src1 = 32'hDEAD_BEEF; src2 = 32'h1234_5678; src3 = 32'd99;
      repeat (3) @(negedge clk);
      check("R8 held", result, held);
      check("R8 held value", held, 32'd31);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_pair_low();
      t_pair_high();
      t_quad();
      t_signed();
      t_src2_unsigned();
      t_wrap();
      t_latency_hold();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule